// File: doc/BRIEF.md
# Trigger and Busy Shift-Extend Gate

This block turns one external trigger line into two results. The line's leading edge is the trigger: the block emits a strobe exactly one clock wide. The whole time the line stays active is read as acquisition dead time. A copy of that level is delayed and then stretched to make a busy window. When the gate is enabled, this window stops the counters. The delay and the stretch make up for cable and logic latency between the readout system and this block.

Two raw lines are available, and a select bit picks one of them. A polarity bit can flip the chosen line before any edge or level logic sees it. The line is synchronised through two flops. The block assumes a 5 ns clock, so the 9-bit delay setting spans 0 to 2555 ns. The 5-bit stretch setting spans 0 to 155 ns. Behaviour is defined only while the stretch is no longer than the busy pulse itself.

Top module: `trig_busy_gate`

## Requirements
- R1: During and right after reset, with the trigger line inactive, `trig_stb_o` is 0, `busy_o` is 0 and `cnt_en_o` is 1.
- R2: When the conditioned line goes active in the cycle before clock edge 1, `trig_stb_o` is high for exactly one cycle, in the cycle that follows edge 2. It stays low for the rest of the pulse, however long the pulse is.
- R3: `src_sel_i` = 1 selects `disc_trig_i` and `src_sel_i` = 0 selects `nim_trig_i`. Activity on the unselected line causes no strobe and no busy.
- R4: `invert_i` = 1 makes the selected line active-low. `invert_i` = 0 makes it active-high.
- R5: With shift 0 and extend 0, a line held active for W clock edges makes `busy_o` high for exactly W cycles. Busy rises in the same cycle as the strobe.
- R6: A shift setting N (0 to 511) delays both the rise and the fall of `busy_o` by exactly N cycles relative to R5.
- R7: An extend setting E (0 to 31) keeps `busy_o` high for exactly E more cycles after the delayed busy has ended.
- R8: With `gate_en_i` = 1, `cnt_en_o` is the inverse of `busy_o` in every cycle. With `gate_en_i` = 0, `cnt_en_o` is 1 in every cycle.
- R9: The largest settings, shift 511 and extend 31, follow the same timing as R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 5 ns period assumed |
| rst_ni | input | 1 | Active-low synchronous reset |
| disc_trig_i | input | 1 | Raw trigger from the discriminator path |
| nim_trig_i | input | 1 | Raw trigger from the NIM path |
| src_sel_i | input | 1 | 1 selects disc_trig_i, 0 selects nim_trig_i |
| invert_i | input | 1 | 1 treats the selected line as active-low |
| shift_i | input | 9 | Busy delay in clock cycles |
| extend_i | input | 5 | Busy stretch in clock cycles |
| gate_en_i | input | 1 | 1 lets busy stop the counters |
| trig_stb_o | output | 1 | One-cycle trigger strobe |
| busy_o | output | 1 | Delayed and stretched busy window |
| cnt_en_o | output | 1 | Counter enable, low while gated by busy |

## Verification
The trigger line is driven at a falling clock edge, and the edges after that are numbered from 1. The strobe is due only in the cycle after edge 2. Busy is due from edge 2+N through edge W+1+N+E. The counter enable follows busy within the same cycle. Every result is sampled at the falling edge that follows each counted rising edge, so each sample sits at a fixed cycle offset from the stimulus. Before each scenario the settings are changed while the line is idle. The bench then waits longer than the full delay line, so no earlier pulse is still in flight.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;

  localparam int unsigned SHIFT_W_DEF = 9;
  localparam int unsigned EXT_W_DEF   = 5;

  // Select the raw source and apply polarity: result is 1 when active.
  function automatic logic cond_level(input logic disc, input logic nim,
                                      input logic sel, input logic inv);
    logic raw;
    raw = sel ? disc : nim;
    return raw ^ inv;
  endfunction

  // Next value of the stretch counter: parked at the setting while the
  // delayed busy is high, then counts down to zero and stops there.
  function automatic logic [EXT_W_DEF-1:0] ext_next(
      input logic                 delayed,
      input logic [EXT_W_DEF-1:0] cur,
      input logic [EXT_W_DEF-1:0] setting);
    if (delayed)       return setting;
    else if (cur != '0) return cur - 1'b1;
    else               return '0;
  endfunction

  // Counter enable from gate bit and busy window.
  function automatic logic count_allowed(input logic gate, input logic busy);
    return !(gate && busy);
  endfunction

endpackage

// File: rtl/trig_cond.sv
module trig_cond
  import trig_busy_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disc_trig_i,
  input  logic nim_trig_i,
  input  logic src_sel_i,
  input  logic invert_i,
  output logic level_o,
  output logic strobe_o
);

  logic cond_w;
  logic sync1_q, sync2_q, prev_q;

  assign cond_w = cond_level(disc_trig_i, nim_trig_i, src_sel_i, invert_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= cond_w;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign level_o  = sync2_q;
  assign strobe_o = sync2_q & ~prev_q;

  // R2: strobe never lasts two cycles
  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  // R2/R4: a strobe traces back to the conditioned line two cycles earlier
  assert_strobe_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(cond_w, 2));

endmodule

// File: rtl/busy_delay.sv
module busy_delay #(
  parameter int unsigned SHIFT_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               level_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               delayed_o
);

  localparam int unsigned DEPTH = 1 << SHIFT_W;

  logic [DEPTH-2:0]   line_q;
  logic [SHIFT_W-1:0] tap_idx;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= {line_q[DEPTH-3:0], level_i};
  end

  assign tap_idx   = shift_i - 1'b1;
  assign delayed_o = (shift_i == '0) ? level_i : line_q[tap_idx];

  // R6: with a settled shift of one, output is the level one cycle back
  assert_shift_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i == SHIFT_W'(1) && $stable(shift_i)) |-> delayed_o == $past(level_i));

endmodule

// File: rtl/busy_extend.sv
module busy_extend
  import trig_busy_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 delayed_i,
  input  logic [EXT_W_DEF-1:0] extend_i,
  output logic                 busy_o,
  output logic                 stretching_o
);

  logic [EXT_W_DEF-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= ext_next(delayed_i, cnt_q, extend_i);
  end

  assign stretching_o = !delayed_i && (cnt_q != '0);
  assign busy_o       = delayed_i || stretching_o;

  // R7: while stretching, the remaining count falls by one per cycle
  assert_stretch_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stretching_o && !delayed_i) |=> (delayed_i || cnt_q == $past(cnt_q) - 1'b1));

  // R7: a nonzero setting keeps busy high right after the delayed busy falls
  assert_stretch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(delayed_i) && $past(extend_i) != '0 && $stable(extend_i)) |-> busy_o);

endmodule

// File: rtl/trig_busy_gate.sv
module trig_busy_gate
  import trig_busy_pkg::*;
#(
  parameter int unsigned SHIFT_W = SHIFT_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               disc_trig_i,
  input  logic               nim_trig_i,
  input  logic               src_sel_i,
  input  logic               invert_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [4:0]         extend_i,
  input  logic               gate_en_i,
  output logic               trig_stb_o,
  output logic               busy_o,
  output logic               cnt_en_o
);

  logic level_w;
  logic delayed_w;
  logic stretching_w;

  trig_cond u_cond (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disc_trig_i (disc_trig_i),
    .nim_trig_i  (nim_trig_i),
    .src_sel_i   (src_sel_i),
    .invert_i    (invert_i),
    .level_o     (level_w),
    .strobe_o    (trig_stb_o)
  );

  busy_delay #(.SHIFT_W(SHIFT_W)) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_w),
    .shift_i   (shift_i),
    .delayed_o (delayed_w)
  );

  busy_extend u_ext (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .delayed_i    (delayed_w),
    .extend_i     (extend_i),
    .busy_o       (busy_o),
    .stretching_o (stretching_w)
  );

  assign cnt_en_o = count_allowed(gate_en_i, busy_o);

  // R8: with the gate off, counting is never held
  assert_gate_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |-> cnt_en_o);

  // R5: with no shift, the strobe cycle is always a busy cycle
  assert_strobe_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_stb_o && shift_i == '0) |-> busy_o);

endmodule

// File: tb/trig_busy_gate_tb_top.sv
module trig_busy_gate_tb_top;

  localparam time CLK_PERIOD = 5ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disc = 1'b0, nim = 1'b0, sel = 1'b1, inv = 1'b0, gate = 1'b0;
  logic [8:0] shift = '0;
  logic [4:0] ext = '0;
  logic       stb, busy, cnt_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_busy_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .disc_trig_i(disc), .nim_trig_i(nim),
    .src_sel_i(sel), .invert_i(inv), .shift_i(shift), .extend_i(ext),
    .gate_en_i(gate), .trig_stb_o(stb), .busy_o(busy), .cnt_en_o(cnt_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_sel(input bit s, input bit active);
    if (s) disc = active ^ inv; else nim = active ^ inv;
  endtask

  // One pulse of W edges on the selected line; checks every cycle.
  task automatic run_pulse(input string tag, input bit s, input bit pol,
                           input int n, input int e, input int w, input bit g);
    @(negedge clk);
    sel = s; inv = pol; shift = 9'(n); ext = 5'(e); gate = g;
    disc = pol; nim = pol;
    repeat (530) @(negedge clk);
    drive_sel(s, 1'b1);
    for (int k = 1; k <= w + n + e + 6; k++) begin
      bit exp_stb, exp_busy, exp_en;
      @(posedge clk);
      @(negedge clk);
      exp_stb  = (k == 2);
      exp_busy = (k >= 2 + n) && (k <= w + 1 + n + e);
      exp_en   = !(g && exp_busy);
      chk(stb == exp_stb, {tag, " strobe R2"}, stb, exp_stb);
      chk(busy == exp_busy, {tag, " busy R5/R6/R7"}, busy, exp_busy);
      chk(cnt_en == exp_en, {tag, " cnt_en R8"}, cnt_en, exp_en);
      if (k == w) drive_sel(s, 1'b0);
    end
  endtask

  task automatic test_reset_r1();
    repeat (3) @(negedge clk);
    chk(stb == 1'b0, "reset strobe R1", stb, 0);
    chk(busy == 1'b0, "reset busy R1", busy, 0);
    chk(cnt_en == 1'b1, "reset cnt_en R1", cnt_en, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(stb == 1'b0 && busy == 1'b0 && cnt_en == 1'b1, "after reset R1",
        {stb, busy, cnt_en}, 3'b001);
  endtask

  // R3: pulse on the unselected line must leave outputs idle
  task automatic test_unselected_r3(input bit s);
    @(negedge clk);
    sel = s; inv = 1'b0; shift = '0; ext = '0; gate = 1'b1;
    disc = 1'b0; nim = 1'b0;
    repeat (530) @(negedge clk);
    if (s) nim = 1'b1; else disc = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 10) begin nim = 1'b0; disc = 1'b0; end
      chk(stb == 1'b0, "unselected strobe R3", stb, 0);
      chk(busy == 1'b0 && cnt_en == 1'b1, "unselected busy R3",
          {busy, cnt_en}, 2'b01);
    end
  endtask

  initial begin
    test_reset_r1();
    run_pulse("base",  1'b1, 1'b0, 0,   0,  6,  1'b1);  // R2 R5 R8
    run_pulse("nim",   1'b0, 1'b0, 0,   0,  4,  1'b1);  // R3
    run_pulse("inv",   1'b1, 1'b1, 0,   0,  5,  1'b1);  // R4
    run_pulse("invn",  1'b0, 1'b1, 3,   2,  7,  1'b1);  // R4 R6 R7
    run_pulse("width1",1'b1, 1'b0, 0,   0,  1,  1'b1);  // R2 R5
    run_pulse("shift", 1'b1, 1'b0, 17,  0,  8,  1'b1);  // R6
    run_pulse("ext",   1'b1, 1'b0, 0,   5,  9,  1'b1);  // R7
    run_pulse("nogate",1'b1, 1'b0, 4,   3,  6,  1'b0);  // R8
    run_pulse("max",   1'b1, 1'b0, 511, 31, 40, 1'b1);  // R9
    test_unselected_r3(1'b1);
    test_unselected_r3(1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule